// File: doc/BRIEF.md
# Two-Group Conversion Sequencer

This block decides which analog channel a shared converter samples next, and when. It keeps two channel lists. The regular list holds up to sixteen ranks and is walked in order. The inserted list holds up to four ranks and has priority over the regular list. A conversion starts from a software start pulse or from an external trigger line of the group, qualified by a selectable edge. Scan, continuous, discontinuous and automatic-inserted mode bits shape the order of conversions. The converter sits behind a simple request/done handshake: the block presents a channel number and holds its request until the converter returns a done pulse with a result.

Results go to a regular data output, with a read strobe, and to one inserted data slot per rank. Five sticky status flags report the events: regular end-of-conversion, inserted end, regular start, inserted start, and regular overrun. They are packed into `flags_o` with bit 0 = regular end, bit 1 = inserted end, bit 2 = regular start, bit 3 = inserted start, bit 4 = overrun. Software clears them with a write strobe: a flag is cleared where the written bit is zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The regular list length is `reg_len_m1`+1 and channel of rank k is `reg_list_i[k*5 +: 5]`. With `scan_en`=1 one start converts ranks 0..`reg_len_m1` in order; with `scan_en`=0 it converts only rank 0.
- R2: The inserted list length is L+1 with L = `inj_len_m1`. Rank r takes its channel from the 5-bit field starting at bit 15-(L-r)*5 of `inj_list_i`, so the last rank always uses bits 19:15. One inserted start converts all ranks in order, and the result of rank r appears on `inj_data_o[r*12 +: 12]`.
- R3: With `disc_reg_en`=1 and `scan_en`=1, each regular start converts the next n = `disc_num_m1`+1 ranks. The burst is cut short at the end of the list. The next start continues from the following rank, and after the last rank the list begins again at rank 0.
- R4: With `disc_inj_en`=1, each inserted start converts one inserted rank. The next start moves on to the following rank.
- R5: Each group has its own 2-bit edge select for its external trigger line: 00 = disabled, 01 = rising edge, 10 = falling edge, 11 = both edges.
- R6: With `eoc_per_conv`=1 the regular end flag is set after every regular conversion. With 0 it is set only after the last rank of the list.
- R7: With `auto_inj_en`=1 the inserted list runs right after the last regular rank is converted, without an inserted start.
- R8: The inserted end flag is set when the last inserted rank is converted. The regular start flag is set when a regular burst or sequence begins. The inserted start flag is set when an inserted run begins.
- R9: The overrun flag is set when a regular result is written while the previous one has not been read by a `reg_data_rd` pulse.
- R10: An inserted start that arrives during a regular scan waits for the conversion in flight to finish. The whole inserted list then runs, and the regular scan resumes at the next rank without losing or repeating a rank.
- R11: With `cont_en`=1 and scan, the regular list starts again at rank 0 after its last rank, until `cont_en` is cleared. The list then ends at its last rank.
- R12: All flags are 0 after reset and stay set until a `flag_wr` pulse writes a zero to them. A set event in the same cycle as the clear wins.
- R13: Only one conversion is outstanding at a time. `conv_req` stays high and `conv_chan` stays stable until `conv_done`. `conv_req` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_list_i | input | 80 | Regular channel list, 5 bits per rank, rank 0 lowest |
| reg_len_m1 | input | 4 | Regular list length minus one |
| inj_list_i | input | 20 | Inserted channel fields, right-aligned by length |
| inj_len_m1 | input | 2 | Inserted list length minus one |
| scan_en | input | 1 | Walk the whole regular list |
| cont_en | input | 1 | Restart the regular list after its end |
| disc_reg_en | input | 1 | Regular bursts of n ranks per start |
| disc_num_m1 | input | 3 | Burst size minus one |
| disc_inj_en | input | 1 | One inserted rank per start |
| auto_inj_en | input | 1 | Run the inserted list after the regular list |
| eoc_per_conv | input | 1 | Regular end flag per conversion (1) or per list (0) |
| reg_edge_sel | input | 2 | Regular trigger edge select |
| inj_edge_sel | input | 2 | Inserted trigger edge select |
| reg_sw_start | input | 1 | Regular software start pulse |
| inj_sw_start | input | 1 | Inserted software start pulse |
| reg_ext_trig | input | 1 | Regular external trigger line |
| inj_ext_trig | input | 1 | Inserted external trigger line |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 12 | Converter result |
| reg_data_rd | input | 1 | Regular result read pulse |
| reg_data_o | output | 12 | Latest regular result |
| inj_data_o | output | 48 | Inserted results, 12 bits per rank |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 5 | Flag write data, zero bits clear |
| flags_o | output | 5 | Sticky status flags |

## Verification
The hardest case to reach is an inserted start landing in the middle of a regular scan. The inserted list must cut in between two regular ranks, and the scan must then pick up at the right rank. The bench models the converter with a fixed latency, starts an eight-rank scan, and fires the inserted start a few cycles later. It then finds the point in the logged channel order where the inserted channel appears. The ranks on both sides of that point must be consecutive and complete. Discontinuous bursts that wrap past the list end are reached by several starts in a row from the vector table.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REG  = 2'd1,
    ST_INJ  = 2'd2
  } seq_state_e;

  localparam int NFLAGS  = 5;
  localparam int FL_EOC  = 0;
  localparam int FL_EOIC = 1;
  localparam int FL_STRC = 2;
  localparam int FL_STIC = 3;
  localparam int FL_OVF  = 4;
endpackage

// File: rtl/adcseq_edge.sv
module adcseq_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_i,
  input  logic [1:0] sel_i,
  output logic       evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign evt_o = (sel_i[0] & sig_i & ~prev_q) | (sel_i[1] & ~sig_i & prev_q);
endmodule

// File: rtl/adcseq_flag.sv
module adcseq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wval_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i && !wval_i) q_d = 1'b0;
    if (set_i)           q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  // R12: a set in the same cycle as a clear leaves the flag set
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R12: writing zero clears the flag when nothing sets it
  a_r12_wzero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wval_i && !set_i) |=> !q_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CHW    = 5,
  parameter int DW     = 12,
  parameter int RSLOTS = 16,
  parameter int ISLOTS = 4,
  parameter int DISCW  = 3,
  localparam int RRW   = $clog2(RSLOTS),
  localparam int IRW   = $clog2(ISLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RSLOTS*CHW-1:0] reg_list_i,
  input  logic [RRW-1:0]        reg_len_m1,
  input  logic [ISLOTS*CHW-1:0] inj_list_i,
  input  logic [IRW-1:0]        inj_len_m1,
  input  logic                  scan_en,
  input  logic                  cont_en,
  input  logic                  disc_reg_en,
  input  logic [DISCW-1:0]      disc_num_m1,
  input  logic                  disc_inj_en,
  input  logic                  auto_inj_en,
  input  logic                  eoc_per_conv,
  input  logic [1:0]            reg_edge_sel,
  input  logic [1:0]            inj_edge_sel,
  input  logic                  reg_sw_start,
  input  logic                  inj_sw_start,
  input  logic                  reg_ext_trig,
  input  logic                  inj_ext_trig,
  output logic                  conv_req,
  output logic [CHW-1:0]        conv_chan,
  input  logic                  conv_done,
  input  logic [DW-1:0]         conv_data,
  input  logic                  reg_data_rd,
  output logic [DW-1:0]         reg_data_o,
  output logic [ISLOTS*DW-1:0]  inj_data_o,
  input  logic                  flag_wr,
  input  logic [NFLAGS-1:0]     flag_wdata,
  output logic [NFLAGS-1:0]     flags_o
);
  localparam logic [IRW-1:0] ITOP = IRW'(ISLOTS - 1);

  // trigger edge qualification, one detector per group
  logic [1:0]      ext_line;
  logic [1:0][1:0] ext_sel;
  logic [1:0]      ext_evt;

  assign ext_line = {inj_ext_trig, reg_ext_trig};
  assign ext_sel  = {inj_edge_sel, reg_edge_sel};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    adcseq_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (ext_line[g]),
      .sel_i (ext_sel[g]),
      .evt_o (ext_evt[g])
    );
  end

  logic reg_go, inj_go;
  assign reg_go = reg_sw_start | ext_evt[0];
  assign inj_go = inj_sw_start | ext_evt[1];

  // state
  seq_state_e                 state_q, state_d;
  logic [RRW-1:0]             reg_rank_q, reg_rank_d;
  logic [DISCW-1:0]           disc_cnt_q, disc_cnt_d;
  logic                       reg_open_q, reg_open_d;
  logic                       reg_resume_q, reg_resume_d;
  logic [IRW-1:0]             inj_rank_q, inj_rank_d;
  logic                       inj_pend_q, inj_pend_d;
  logic                       reg_valid_q, reg_valid_d;
  logic [DW-1:0]              reg_data_q, reg_data_d;
  logic [ISLOTS-1:0][DW-1:0]  inj_data_q, inj_data_d;
  logic [NFLAGS-1:0]          flag_set;

  logic           reg_last, burst_end, reg_more, inj_last;
  logic [IRW-1:0] inj_slot;

  assign reg_last  = !scan_en || (reg_rank_q == reg_len_m1);
  assign burst_end = disc_reg_en && (disc_cnt_q == disc_num_m1);
  assign reg_more  = reg_last ? cont_en : !burst_end;
  assign inj_last  = (inj_rank_q == inj_len_m1);
  // right-aligned packing: the last rank always uses the top field
  assign inj_slot  = IRW'(inj_rank_q + (ITOP - inj_len_m1));

  always_comb begin
    state_d      = state_q;
    reg_rank_d   = reg_rank_q;
    disc_cnt_d   = disc_cnt_q;
    reg_open_d   = reg_open_q;
    reg_resume_d = reg_resume_q;
    inj_rank_d   = inj_rank_q;
    inj_pend_d   = inj_pend_q | (inj_go & (state_q != ST_INJ));
    reg_valid_d  = reg_valid_q & ~reg_data_rd;
    reg_data_d   = reg_data_q;
    inj_data_d   = inj_data_q;
    flag_set     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (inj_pend_d) begin
          state_d           = ST_INJ;
          inj_pend_d        = 1'b0;
          flag_set[FL_STIC] = 1'b1;
        end else if (reg_go) begin
          state_d           = ST_REG;
          flag_set[FL_STRC] = 1'b1;
          reg_open_d        = 1'b1;
          if (!reg_open_q) begin
            reg_rank_d = '0;
            disc_cnt_d = '0;
          end
        end
      end
      ST_REG: begin
        if (conv_done) begin
          reg_data_d  = conv_data;
          reg_valid_d = 1'b1;
          if (reg_valid_q && !reg_data_rd) flag_set[FL_OVF] = 1'b1;
          if (eoc_per_conv || reg_last)    flag_set[FL_EOC] = 1'b1;
          if (reg_last) begin
            reg_rank_d = '0;
            disc_cnt_d = '0;
            reg_open_d = cont_en;
          end else begin
            reg_rank_d = RRW'(reg_rank_q + 1'b1);
            disc_cnt_d = burst_end ? '0 : DISCW'(disc_cnt_q + 1'b1);
          end
          if (inj_pend_d || (auto_inj_en && reg_last)) begin
            state_d           = ST_INJ;
            inj_pend_d        = 1'b0;
            flag_set[FL_STIC] = 1'b1;
            reg_resume_d      = reg_more;
          end else if (reg_more) begin
            if (reg_last) flag_set[FL_STRC] = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_INJ: begin
        if (conv_done) begin
          inj_data_d[inj_rank_q] = conv_data;
          if (inj_last) begin
            flag_set[FL_EOIC] = 1'b1;
            inj_rank_d        = '0;
          end else begin
            inj_rank_d = IRW'(inj_rank_q + 1'b1);
          end
          if (inj_last || disc_inj_en) begin
            if (reg_resume_q) begin
              state_d      = ST_REG;
              reg_resume_d = 1'b0;
              if (reg_rank_q == '0) flag_set[FL_STRC] = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      reg_rank_q   <= '0;
      disc_cnt_q   <= '0;
      reg_open_q   <= 1'b0;
      reg_resume_q <= 1'b0;
      inj_rank_q   <= '0;
      inj_pend_q   <= 1'b0;
      reg_valid_q  <= 1'b0;
      reg_data_q   <= '0;
      inj_data_q   <= '0;
    end else begin
      state_q      <= state_d;
      reg_rank_q   <= reg_rank_d;
      disc_cnt_q   <= disc_cnt_d;
      reg_open_q   <= reg_open_d;
      reg_resume_q <= reg_resume_d;
      inj_rank_q   <= inj_rank_d;
      inj_pend_q   <= inj_pend_d;
      reg_valid_q  <= reg_valid_d;
      reg_data_q   <= reg_data_d;
      inj_data_q   <= inj_data_d;
    end
  end

  // sticky flags
  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    adcseq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[f]),
      .wr_i   (flag_wr),
      .wval_i (flag_wdata[f]),
      .q_o    (flags_o[f])
    );
  end

  assign conv_req   = (state_q != ST_IDLE);
  assign conv_chan  = (state_q == ST_INJ) ? inj_list_i[inj_slot*CHW +: CHW]
                                          : reg_list_i[reg_rank_q*CHW +: CHW];
  assign reg_data_o = reg_data_q;
  assign inj_data_o = inj_data_q;

  // R13: a request is held with a stable channel until done
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));
  // R9: unread regular result overwritten raises overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REG && conv_done && reg_valid_q && !reg_data_rd) |=> flags_o[FL_OVF]);
  // R8: last inserted rank done raises the inserted end flag
  a_r8_inj_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INJ && conv_done && inj_last) |=> flags_o[FL_EOIC]);
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [79:0] reg_list;
  logic [3:0]  reg_len_m1;
  logic [19:0] inj_list;
  logic [1:0]  inj_len_m1;
  logic        scan_en, cont_en, disc_reg_en, disc_inj_en, auto_inj_en, eoc_per_conv;
  logic [2:0]  disc_num_m1;
  logic [1:0]  reg_edge_sel, inj_edge_sel;
  logic        reg_sw_start, inj_sw_start, reg_ext_trig, inj_ext_trig;
  logic        conv_req, conv_done;
  logic [4:0]  conv_chan;
  logic [11:0] conv_data;
  logic        reg_data_rd;
  logic [11:0] reg_data;
  logic [47:0] inj_data;
  logic        flag_wr;
  logic [4:0]  flag_wdata;
  logic [4:0]  flags;

  int n_chk = 0;
  int n_fail = 0;
  int nconv = 0;
  logic [4:0] logv [512];
  int cnt_m;

  always #2 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_list_i(reg_list), .reg_len_m1(reg_len_m1),
    .inj_list_i(inj_list), .inj_len_m1(inj_len_m1), .scan_en(scan_en),
    .cont_en(cont_en), .disc_reg_en(disc_reg_en), .disc_num_m1(disc_num_m1),
    .disc_inj_en(disc_inj_en), .auto_inj_en(auto_inj_en), .eoc_per_conv(eoc_per_conv),
    .reg_edge_sel(reg_edge_sel), .inj_edge_sel(inj_edge_sel),
    .reg_sw_start(reg_sw_start), .inj_sw_start(inj_sw_start),
    .reg_ext_trig(reg_ext_trig), .inj_ext_trig(inj_ext_trig),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .reg_data_rd(reg_data_rd), .reg_data_o(reg_data),
    .inj_data_o(inj_data), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flags_o(flags)
  );

  function automatic logic [11:0] fres(input logic [4:0] ch);
    return 12'(ch * 37 + 5);
  endfunction

  // converter model with fixed latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_done <= 1'b0;
      conv_data <= '0;
      cnt_m     <= 0;
    end else if (conv_done) begin
      conv_done <= 1'b0;
    end else if (conv_req) begin
      if (cnt_m == LAT - 1) begin
        conv_done <= 1'b1;
        conv_data <= fres(conv_chan);
        cnt_m     <= 0;
      end else cnt_m <= cnt_m + 1;
    end else cnt_m <= 0;
  end

  // conversion log
  always @(posedge clk) begin
    if (rst_n && conv_done) begin
      logv[nconv % 512] <= conv_chan;
      nconv <= nconv + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_len_m1 = '0; inj_list = '0; inj_len_m1 = '0;
    scan_en = 0; cont_en = 0; disc_reg_en = 0; disc_inj_en = 0; auto_inj_en = 0;
    eoc_per_conv = 0; disc_num_m1 = '0; reg_edge_sel = '0; inj_edge_sel = '0;
    reg_sw_start = 0; inj_sw_start = 0; reg_ext_trig = 0; inj_ext_trig = 0;
    reg_data_rd = 0; flag_wr = 0; flag_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 3000 && q < 10; i++) begin
      @(negedge clk);
      if (!conv_req && !conv_done) q++; else q = 0;
    end
  endtask

  task automatic pulse_reg();
    @(negedge clk); reg_sw_start = 1'b1;
    @(negedge clk); reg_sw_start = 1'b0;
  endtask

  task automatic pulse_inj();
    @(negedge clk); inj_sw_start = 1'b1;
    @(negedge clk); inj_sw_start = 1'b0;
  endtask

  task automatic write_flags(input logic [4:0] v);
    @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk); flag_wr = 1'b0; flag_wdata = '0;
  endtask

  // {scan, len_m1[3:0], disc, dnum_m1[2:0], eoc_per, ntrig[1:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 4'd5,  1'b0, 3'd0, 1'b0, 2'd1},
    {1'b1, 4'd3,  1'b0, 3'd0, 1'b0, 2'd1},
    {1'b1, 4'd15, 1'b0, 3'd0, 1'b1, 2'd1},
    {1'b1, 4'd4,  1'b1, 3'd1, 1'b0, 2'd1},
    {1'b1, 4'd4,  1'b1, 3'd1, 1'b1, 2'd1},
    {1'b1, 4'd4,  1'b1, 3'd2, 1'b0, 2'd2},
    {1'b1, 4'd2,  1'b1, 3'd7, 1'b0, 2'd3},
    {1'b1, 4'd0,  1'b0, 3'd0, 1'b0, 2'd2}
  };

  initial begin
    int base, nexp, erank, bad, p, d;
    logic reached_end;
    logic [4:0] expv [64];
    for (int k = 0; k < 16; k++) reg_list[k*5 +: 5] = 5'(k);
    rst_n = 1'b0;
    do_reset();

    // reset state
    check(flags == 5'd0, "R12 flags after reset", flags, 0);
    check(conv_req == 1'b0, "R13 no request after reset", conv_req, 0);

    // vector table: regular list modes
    for (int v = 0; v < 8; v++) begin
      logic [11:0] e;
      int len, n;
      e = VEC[v];
      do_reset();
      scan_en = e[11]; reg_len_m1 = e[10:7]; disc_reg_en = e[6];
      disc_num_m1 = e[5:3]; eoc_per_conv = e[2];
      len = int'(e[10:7]) + 1; n = int'(e[5:3]) + 1;
      base = nconv; nexp = 0; erank = 0; reached_end = 0;
      for (int t = 0; t < int'(e[1:0]); t++) begin
        pulse_reg();
        wait_quiet();
        if (!e[11]) begin
          expv[nexp++] = 5'd0; reached_end = 1;
        end else if (!e[6]) begin
          for (int j = 0; j < len; j++) expv[nexp++] = 5'(j);
          reached_end = 1;
        end else begin
          for (int j = 0; j < n; j++) begin
            expv[nexp++] = 5'(erank);
            erank++;
            if (erank >= len) begin erank = 0; reached_end = 1; break; end
          end
        end
      end
      bad = 0;
      for (int j = 0; j < nexp && j < nconv - base; j++)
        if (logv[(base + j) % 512] != expv[j]) bad++;
      check(nconv - base == nexp, $sformatf("R1 R3 vec%0d conversion count", v), nconv - base, nexp);
      check(bad == 0, $sformatf("R1 R3 vec%0d channel order mismatches", v), bad, 0);
      check(flags[0] == (e[2] | reached_end), $sformatf("R6 vec%0d end flag", v),
            flags[0], int'(e[2] | reached_end));
      check(flags[4] == (nexp > 1), $sformatf("R9 vec%0d overrun flag", v), flags[4], int'(nexp > 1));
      check(flags[2] == 1'b1, $sformatf("R8 vec%0d regular start flag", v), flags[2], 1);
    end

    // R2: inserted packing, length 3 uses fields 1..3
    do_reset();
    inj_len_m1 = 2'd2;
    inj_list = {5'd18, 5'd17, 5'd16, 5'd5};
    base = nconv;
    pulse_inj(); wait_quiet();
    check(nconv - base == 3, "R2 inserted count", nconv - base, 3);
    check(logv[base % 512] == 5'd16 && logv[(base+1) % 512] == 5'd17 && logv[(base+2) % 512] == 5'd18,
          "R2 inserted order first channel", logv[base % 512], 16);
    check(inj_data[0 +: 12] == fres(5'd16), "R2 inserted slot0", inj_data[0 +: 12], fres(5'd16));
    check(inj_data[24 +: 12] == fres(5'd18), "R2 inserted slot2", inj_data[24 +: 12], fres(5'd18));
    check(flags == 5'b01010, "R8 inserted end and start flags", flags, 10);

    // R4: discontinuous inserted, one rank per start
    do_reset();
    inj_len_m1 = 2'd2; inj_list = {5'd18, 5'd17, 5'd16, 5'd5}; disc_inj_en = 1;
    base = nconv;
    pulse_inj(); wait_quiet();
    check(nconv - base == 1 && logv[base % 512] == 5'd16, "R4 one rank per start", nconv - base, 1);
    check(flags[1] == 1'b0, "R4 no inserted end yet", flags[1], 0);
    pulse_inj(); wait_quiet(); pulse_inj(); wait_quiet();
    check(nconv - base == 3 && logv[(base+2) % 512] == 5'd18, "R4 third start last rank", nconv - base, 3);
    check(flags[1] == 1'b1, "R4 inserted end after last rank", flags[1], 1);

    // R5: edge selection
    do_reset();
    inj_len_m1 = 2'd0; inj_list = {5'd18, 15'd0};
    inj_edge_sel = 2'b01;
    base = nconv; @(negedge clk); inj_ext_trig = 1; wait_quiet();
    check(nconv - base == 1, "R5 rising edge select, rise", nconv - base, 1);
    base = nconv; @(negedge clk); inj_ext_trig = 0; wait_quiet();
    check(nconv - base == 0, "R5 rising edge select, fall", nconv - base, 0);
    inj_edge_sel = 2'b10;
    base = nconv; @(negedge clk); inj_ext_trig = 1; wait_quiet();
    d = nconv - base;
    base = nconv; @(negedge clk); inj_ext_trig = 0; wait_quiet();
    check(d == 0 && nconv - base == 1, "R5 falling edge select", nconv - base, 1);
    inj_edge_sel = 2'b11;
    base = nconv; @(negedge clk); inj_ext_trig = 1; wait_quiet();
    @(negedge clk); inj_ext_trig = 0; wait_quiet();
    check(nconv - base == 2, "R5 both edges select", nconv - base, 2);
    inj_edge_sel = 2'b00; reg_edge_sel = 2'b01;
    base = nconv; @(negedge clk); inj_ext_trig = 1; reg_ext_trig = 1; wait_quiet();
    check(nconv - base == 1 && logv[base % 512] == 5'd0, "R5 disabled inserted, armed regular",
          nconv - base, 1);

    // R10: inserted start in the middle of a regular scan
    do_reset();
    scan_en = 1; reg_len_m1 = 4'd7; inj_len_m1 = 2'd0; inj_list = {5'd18, 15'd0};
    base = nconv;
    pulse_reg(); repeat (6) @(negedge clk); pulse_inj(); wait_quiet();
    p = -1;
    for (int j = 0; j < nconv - base; j++) if (p < 0 && logv[(base + j) % 512] == 5'd18) p = j;
    bad = 0;
    for (int j = 0; j < nconv - base; j++)
      if (j != p && logv[(base + j) % 512] != 5'((j < p) ? j : j - 1)) bad++;
    check(nconv - base == 9, "R10 total with pre-emption", nconv - base, 9);
    check(p >= 1 && p <= 7 && bad == 0, "R10 resume at next rank, mismatches", bad, 0);

    // R7: automatic inserted after the regular list
    do_reset();
    scan_en = 1; reg_len_m1 = 4'd2; auto_inj_en = 1; inj_len_m1 = 2'd0; inj_list = {5'd18, 15'd0};
    base = nconv;
    pulse_reg(); wait_quiet();
    check(nconv - base == 4 && logv[(base+3) % 512] == 5'd18 && logv[(base+2) % 512] == 5'd2,
          "R7 inserted follows last regular rank", nconv - base, 4);
    check(flags[1] == 1'b1, "R7 inserted end flag", flags[1], 1);

    // R11: continuous restarts, stops at list end after clearing
    do_reset();
    scan_en = 1; reg_len_m1 = 4'd1; cont_en = 1;
    base = nconv;
    pulse_reg(); repeat (60) @(negedge clk); cont_en = 0; wait_quiet();
    bad = 0;
    for (int j = 0; j < nconv - base; j++) if (logv[(base + j) % 512] != 5'(j % 2)) bad++;
    check((nconv - base) >= 6 && ((nconv - base) % 2) == 0, "R11 continuous count even and long",
          nconv - base, 6);
    check(bad == 0, "R11 continuous rank order mismatches", bad, 0);

    // R9: reading between results avoids overrun
    do_reset();
    pulse_reg(); wait_quiet();
    @(negedge clk); reg_data_rd = 1; @(negedge clk); reg_data_rd = 0;
    pulse_reg(); wait_quiet();
    check(flags[4] == 1'b0, "R9 no overrun when read", flags[4], 0);
    check(reg_data == fres(5'd0), "R9 regular data value", reg_data, fres(5'd0));

    // R12: write-zero clear, written ones keep flags
    write_flags(5'b00001);
    check(flags == 5'b00001, "R12 partial clear keeps end flag", flags, 1);
    write_flags(5'b00000);
    check(flags == 5'b00000, "R12 full clear", flags, 0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule